// File: doc/BRIEF.md
# Video Interface Activity Detector and Power Arbiter

This block watches a dual-input display front end that can take either an analog RGB feed or a digital serial link, and decides which of the two paths gets power. On the analog side it monitors the horizontal sync, vertical sync and sync-on-green slicer outputs. On the digital side it first looks for a running link clock. Once that path has been powered up, it qualifies the link by counting data-enable pulses. Only one path is powered at a time, and both are switched off when nothing is active.

Each monitored signal has a watcher. The watcher restarts a timeout on every level change and counts down on a shared slow tick. When the timeout expires, the signal's status bit drops. With `TIMEOUT_TICKS` = 8 and a tick period of at most 12.5 ms, loss of a signal is reported within 100 ms. The choice of path follows a fixed priority: a power-down request comes first, then a manual override with its own select bit, then automatic detection. Under automatic detection the analog path wins when both paths are live.

Top module: `vif_pwr_arb`

## Requirements
- R1: Out of reset all status bits, `de_lock_o`, `sel_dig_o` and both power enables are 0. A status bit (`sync_act_o` bit 0 = hsync, bit 1 = vsync, bit 2 = sync-on-green) goes to 1 on the clock edge where its input differs from the value sampled at the previous edge. The sampled value starts at 0 after reset.
- R2: A status bit goes back to 0 on the `TIMEOUT_TICKS`-th `tick_i` pulse with no level change since the last change. A change on the same edge as a tick restarts the count.
- R3: The analog path counts as detected when any one of the three sync status bits is set, including sync-on-green alone.
- R4: `lclk_act_o` follows the same rule as R1/R2 on `lclk_i`, and it keeps updating while the digital path is unpowered.
- R5: While `dig_pwr_o` is 1, `de_lock_o` rises on the edge that samples the `DE_PULSES`-th consecutive rising edge of `de_i`.
- R6: If `DE_GAP_CYC` cycles pass without a rising edge of `de_i` before lock, the pulse count restarts from zero.
- R7: Once set, `de_lock_o` holds through data-enable gaps. It clears on the edge after `dig_pwr_o` is 0.
- R8: With `pdn_i` = 1 both power enables are 0, whatever the override and detection state.
- R9: With `pdn_i` = 0 and `ovr_en_i` = 1, `sel_dig_o` equals `ovr_sel_i` (1 = digital) and only the selected path is powered, even with no activity.
- R10: With `pdn_i` = 0 and `ovr_en_i` = 0, the analog path is selected and powered when it is detected. Otherwise the digital path is selected and powered when `lclk_act_o` is 1. Otherwise `sel_dig_o` is 0 and both paths are off.
- R11: The sync status bits keep setting and timing out while the digital path is powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow timebase pulse, one cycle wide |
| hsync_i | input | 1 | Horizontal sync activity, synchronous |
| vsync_i | input | 1 | Vertical sync activity, synchronous |
| sog_i | input | 1 | Sync-on-green slicer output, synchronous |
| lclk_i | input | 1 | Digital link clock activity, synchronous |
| de_i | input | 1 | Digital data enable, synchronous |
| ovr_en_i | input | 1 | Manual interface override enable |
| ovr_sel_i | input | 1 | Override choice: 0 analog, 1 digital |
| pdn_i | input | 1 | Power-down request |
| sync_act_o | output | 3 | Sync status: bit 0 hsync, bit 1 vsync, bit 2 sync-on-green |
| lclk_act_o | output | 1 | Link clock status |
| de_lock_o | output | 1 | Digital link qualified by data-enable pulses |
| sel_dig_o | output | 1 | Active interface: 0 analog, 1 digital |
| ana_pwr_o | output | 1 | Analog path power enable |
| dig_pwr_o | output | 1 | Digital path power enable |

## Verification
The assertions assume that every activity input and `de_i` is already synchronous to `clk_i`, changes at most once per cycle, and that `tick_i` is a single-cycle pulse. The bench meets these assumptions by driving all inputs from one process shortly after the rising edge. Periodic toggles and ticks are derived from a common cycle counter. The power-down, override and enable controls change only at cycle boundaries, so each priority level and every detection transition is seen with settled inputs.

// File: rtl/vif_pwr_pkg.sv
package vif_pwr_pkg;
  typedef enum logic {
    IF_ANA = 1'b0,
    IF_DIG = 1'b1
  } if_sel_e;

  localparam int unsigned NUM_SYNC = 3;
  localparam int unsigned SYNC_HS  = 0;
  localparam int unsigned SYNC_VS  = 1;
  localparam int unsigned SYNC_SOG = 2;
endpackage

// File: rtl/vif_act_watch.sv
module vif_act_watch #(
  parameter int unsigned TIMEOUT_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sig_i,
  output logic act_o
);
  localparam int unsigned TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_TICKS - 1);

  logic          prev_q;
  logic          act_q;
  logic [TW-1:0] tmr_q;
  logic          chg;

  assign chg = sig_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      act_q  <= 1'b0;
      tmr_q  <= '0;
    end else begin
      prev_q <= sig_i;
      if (chg) begin
        act_q <= 1'b1;
        tmr_q <= '0;
      end else if (tick_i) begin
        // saturate at the limit; status stays low until next change
        if (tmr_q == T_LAST) act_q <= 1'b0;
        else                 tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/vif_de_qual.sv
module vif_de_qual #(
  parameter int unsigned DE_PULSES  = 32,
  parameter int unsigned DE_GAP_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic de_i,
  output logic lock_o
);
  localparam int unsigned CW = (DE_PULSES > 1) ? $clog2(DE_PULSES) : 1;
  localparam int unsigned GW = (DE_GAP_CYC > 1) ? $clog2(DE_GAP_CYC) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(DE_PULSES - 1);
  localparam logic [GW-1:0] G_LAST = GW'(DE_GAP_CYC - 1);

  logic          de_prev_q;
  logic          lock_q;
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] gap_q;
  logic          de_rise;

  assign de_rise = de_i & ~de_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_prev_q <= 1'b0;
      lock_q    <= 1'b0;
      cnt_q     <= '0;
      gap_q     <= '0;
    end else begin
      de_prev_q <= de_i;
      if (!en_i) begin
        lock_q <= 1'b0;
        cnt_q  <= '0;
        gap_q  <= '0;
      end else if (!lock_q) begin
        if (de_rise) begin
          gap_q <= '0;
          if (cnt_q == C_LAST) lock_q <= 1'b1;
          else                 cnt_q  <= cnt_q + 1'b1;
        end else if (gap_q == G_LAST) begin
          cnt_q <= '0;  // run broken, start over
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/vif_pwr_decide.sv
module vif_pwr_decide
  import vif_pwr_pkg::*;
(
  input  logic    pdn_i,
  input  logic    ovr_en_i,
  input  logic    ovr_sel_i,
  input  logic    ana_det_i,
  input  logic    dig_det_i,
  output if_sel_e sel_o,
  output logic    ana_pwr_o,
  output logic    dig_pwr_o
);
  logic path_on;

  always_comb begin
    if (ovr_en_i) begin
      sel_o   = ovr_sel_i ? IF_DIG : IF_ANA;
      path_on = 1'b1;
    end else begin
      sel_o   = (!ana_det_i && dig_det_i) ? IF_DIG : IF_ANA;
      path_on = ana_det_i | dig_det_i;
    end
    ana_pwr_o = !pdn_i && path_on && (sel_o == IF_ANA);
    dig_pwr_o = !pdn_i && path_on && (sel_o == IF_DIG);
  end
endmodule

// File: rtl/vif_pwr_arb.sv
module vif_pwr_arb
  import vif_pwr_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 8,
  parameter int unsigned DE_PULSES     = 32,
  parameter int unsigned DE_GAP_CYC    = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hsync_i,
  input  logic       vsync_i,
  input  logic       sog_i,
  input  logic       lclk_i,
  input  logic       de_i,
  input  logic       ovr_en_i,
  input  logic       ovr_sel_i,
  input  logic       pdn_i,
  output logic [2:0] sync_act_o,
  output logic       lclk_act_o,
  output logic       de_lock_o,
  output logic       sel_dig_o,
  output logic       ana_pwr_o,
  output logic       dig_pwr_o
);
  logic [NUM_SYNC-1:0] sync_in;
  logic [NUM_SYNC-1:0] sync_act;
  logic                lclk_act;
  if_sel_e             sel;
  logic                dig_pwr;

  assign sync_in[SYNC_HS]  = hsync_i;
  assign sync_in[SYNC_VS]  = vsync_i;
  assign sync_in[SYNC_SOG] = sog_i;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
    vif_act_watch #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_watch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .sig_i (sync_in[g]),
      .act_o (sync_act[g])
    );
  end

  // link clock watcher is never gated by path power
  vif_act_watch #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_lclk_watch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .sig_i (lclk_i),
    .act_o (lclk_act)
  );

  vif_de_qual #(.DE_PULSES(DE_PULSES), .DE_GAP_CYC(DE_GAP_CYC)) u_de_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (dig_pwr),
    .de_i  (de_i),
    .lock_o(de_lock_o)
  );

  vif_pwr_decide u_decide (
    .pdn_i    (pdn_i),
    .ovr_en_i (ovr_en_i),
    .ovr_sel_i(ovr_sel_i),
    .ana_det_i(|sync_act),
    .dig_det_i(lclk_act),
    .sel_o    (sel),
    .ana_pwr_o(ana_pwr_o),
    .dig_pwr_o(dig_pwr)
  );

  assign sync_act_o = sync_act;
  assign lclk_act_o = lclk_act;
  assign sel_dig_o  = (sel == IF_DIG);
  assign dig_pwr_o  = dig_pwr;
endmodule

// File: rtl/vif_pwr_arb_chk.sv
module vif_pwr_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hsync_i,
  input logic       de_i,
  input logic       pdn_i,
  input logic       ovr_en_i,
  input logic [2:0] sync_act_o,
  input logic       de_lock_o,
  input logic       ana_pwr_o,
  input logic       dig_pwr_o
);
  p_hs_change_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i != $past(hsync_i)) |=> sync_act_o[0]);

  p_one_path_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ana_pwr_o && dig_pwr_o));

  p_pdn_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |-> (!ana_pwr_o && !dig_pwr_o));

  p_auto_ana_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_i && !ovr_en_i && (|sync_act_o)) |-> ana_pwr_o);

  p_lock_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dig_pwr_o |=> !de_lock_o);

  p_lock_on_de_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_lock_o) |-> $past(de_i));
endmodule

bind vif_pwr_arb vif_pwr_arb_chk u_chk (.*);

// File: tb/vif_pwr_arb_tb_top.sv
module vif_pwr_arb_tb_top;
  localparam int TO   = 8;
  localparam int NPUL = 32;
  localparam int GAP  = 64;
  localparam int TDIV = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, hsync_i = 0, vsync_i = 0, sog_i = 0, lclk_i = 0, de_i = 0;
  logic ovr_en_i = 0, ovr_sel_i = 0, pdn_i = 0;
  logic [2:0] sync_act_o;
  logic lclk_act_o, de_lock_o, sel_dig_o, ana_pwr_o, dig_pwr_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit hs_en = 0, vs_en = 0, sog_en = 0, lk_en = 0, de_en = 0, done = 0;

  always #5 clk_i = ~clk_i;

  vif_pwr_arb dut_i (.*);

  // stimulus generator, all inputs change 2 time units after the edge
  always @(posedge clk_i) begin
    #2;
    cyc++;
    tick_i = (cyc % TDIV == 0);
    if (hs_en && cyc % 3 == 0) hsync_i = ~hsync_i;
    if (vs_en && cyc % 4 == 0) vsync_i = ~vsync_i;
    if (sog_en && cyc % 5 == 0) sog_i = ~sog_i;
    if (lk_en) lclk_i = ~lclk_i;
    de_i = de_en && (cyc % 6 < 3);
  end

  // behavioural reference model
  int m_prev[4], m_tmr[4], m_act[4];
  int m_de_prev, m_cnt, m_gap, m_lock;

  function automatic int f_ana_det();
    return (m_act[0] | m_act[1] | m_act[2]);
  endfunction
  function automatic int f_sel();
    if (ovr_en_i) return int'(ovr_sel_i);
    return (!f_ana_det() && m_act[3]) ? 1 : 0;
  endfunction
  function automatic int f_on();
    return ovr_en_i ? 1 : (f_ana_det() | m_act[3]);
  endfunction
  function automatic int f_ana_pwr();
    return (!pdn_i && f_on() && f_sel() == 0) ? 1 : 0;
  endfunction
  function automatic int f_dig_pwr();
    return (!pdn_i && f_on() && f_sel() == 1) ? 1 : 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) begin m_prev[i] = 0; m_tmr[i] = 0; m_act[i] = 0; end
      m_de_prev = 0; m_cnt = 0; m_gap = 0; m_lock = 0;
    end else begin
      int dp, ins[4];
      dp = f_dig_pwr();
      ins[0] = hsync_i; ins[1] = vsync_i; ins[2] = sog_i; ins[3] = lclk_i;
      for (int i = 0; i < 4; i++) begin
        if (ins[i] != m_prev[i]) begin m_act[i] = 1; m_tmr[i] = 0; end
        else if (tick_i) begin
          if (m_tmr[i] == TO - 1) m_act[i] = 0; else m_tmr[i]++;
        end
        m_prev[i] = ins[i];
      end
      if (!dp) begin m_cnt = 0; m_gap = 0; m_lock = 0; end
      else if (!m_lock) begin
        if (de_i && !m_de_prev) begin
          m_gap = 0;
          if (m_cnt == NPUL - 1) m_lock = 1; else m_cnt++;
        end else if (m_gap == GAP - 1) m_cnt = 0;
        else m_gap++;
      end
      m_de_prev = de_i;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R1/R2 sync_act", int'(sync_act_o), m_act[0] + 2 * m_act[1] + 4 * m_act[2]);
      chk("R4 lclk_act", int'(lclk_act_o), m_act[3]);
      chk("R5/R6/R7 de_lock", int'(de_lock_o), m_lock);
      chk("R9/R10 sel", int'(sel_dig_o), f_sel());
      chk("R8/R10 ana_pwr", int'(ana_pwr_o), f_ana_pwr());
      chk("R8/R10 dig_pwr", int'(dig_pwr_o), f_dig_pwr());
    end
  end

  task automatic waitc(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic at_neg();
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
    finish_run();
  end

  initial begin
    waitc(3);
    at_neg();
    chk("R1 reset sync_act", int'(sync_act_o), 0);
    chk("R1 reset power", int'({ana_pwr_o, dig_pwr_o, de_lock_o, sel_dig_o}), 0);
    rst_ni = 1'b1;
    // hsync alone
    waitc(1); hs_en = 1;
    waitc(40); at_neg();
    chk("R1 hsync status", int'(sync_act_o[0]), 1);
    chk("R10 analog powered", int'(ana_pwr_o), 1);
    // timeout
    waitc(1); hs_en = 0;
    waitc(20); at_neg();
    chk("R2 status held before timeout", int'(sync_act_o[0]), 1);
    waitc(30); at_neg();
    chk("R2 status cleared after timeout", int'(sync_act_o[0]), 0);
    chk("R10 nothing active both off", int'({ana_pwr_o, dig_pwr_o}), 0);
    // digital clock then DE qualification
    waitc(1); lk_en = 1;
    waitc(20); at_neg();
    chk("R4 lclk status", int'(lclk_act_o), 1);
    chk("R10 digital powered", int'(dig_pwr_o), 1);
    chk("R10 digital selected", int'(sel_dig_o), 1);
    waitc(1); de_en = 1;
    waitc(120); de_en = 0;
    waitc(80); de_en = 1;
    waitc(150); at_neg();
    chk("R6 count restarted after gap", int'(de_lock_o), 0);
    waitc(60); at_neg();
    chk("R5 locked after full run", int'(de_lock_o), 1);
    waitc(1); de_en = 0;
    waitc(100); at_neg();
    chk("R7 lock holds through gap", int'(de_lock_o), 1);
    // analog appears: analog wins, digital unpowered
    waitc(1); vs_en = 1;
    waitc(10); at_neg();
    chk("R10 analog wins", int'({ana_pwr_o, dig_pwr_o}), 2);
    chk("R7 lock cleared when unpowered", int'(de_lock_o), 0);
    chk("R4 lclk still sensed unpowered", int'(lclk_act_o), 1);
    // override to digital
    waitc(1); ovr_en_i = 1; ovr_sel_i = 1;
    waitc(2); at_neg();
    chk("R9 override digital", int'({ana_pwr_o, dig_pwr_o}), 1);
    waitc(1); vs_en = 0;
    waitc(50); at_neg();
    chk("R11 vsync times out while digital", int'(sync_act_o[1]), 0);
    waitc(1); sog_en = 1;
    waitc(10); at_neg();
    chk("R11 sog sensed while digital", int'(sync_act_o[2]), 1);
    waitc(1); ovr_sel_i = 0;
    waitc(1); at_neg();
    chk("R9 override analog", int'({ana_pwr_o, dig_pwr_o, sel_dig_o}), 4);
    // power-down priority
    waitc(1); pdn_i = 1;
    waitc(1); at_neg();
    chk("R8 pdn over override", int'({ana_pwr_o, dig_pwr_o}), 0);
    waitc(1); ovr_en_i = 0;
    waitc(1); at_neg();
    chk("R8 pdn over auto", int'({ana_pwr_o, dig_pwr_o}), 0);
    waitc(1); pdn_i = 0;
    waitc(1); at_neg();
    chk("R3 sog alone detects analog", int'(ana_pwr_o), 1);
    finish_run();
  end
endmodule